// File: doc/BRIEF.md
# Eight-Line Prioritizing Interrupt Controller

This block gathers eight interrupt request lines into one interrupt output for a processor. Each request line is edge-sensitive. A rising edge latches a pending bit in the request register, and a mask register gates the pending bits. A fixed priority scan then picks a winner, with input 0 as the most urgent. A request is only offered to the processor when it outranks every level already in service, so service is fully nested.

The processor takes an interrupt in one of two ways. It can issue two acknowledge strobes. The first strobe moves the winner from the request register into the in-service register. The second strobe outputs an 8-bit vector built from a programmable base and the level number. Where no acknowledge bus cycle exists, software can instead write a poll command to the command port. The next read of that port returns the winning level and accepts it exactly as an acknowledge would. Software can also read the raw request register or the in-service register back through the same port. A non-specific end-of-interrupt command retires the most urgent level in service. If no eligible request remains when the first strobe arrives, the block reports level 7 and leaves the in-service register untouched, so software can recognise a false interrupt.

Top module: `irq_ctrl8`

## Requirements
- R1: A 0-to-1 transition on `req_in[i]` sets request bit i. The bit stays set, whatever the line does, until that level is accepted. A line held high after acceptance does not set the bit again.
- R2: `int_out` is high exactly when some request bit i is set, mask bit i is clear, and no in-service bit at index i or lower is set.
- R3: Among eligible requests, the lowest index always wins.
- R4: On the first `inta` strobe, the winning request bit is cleared and the matching in-service bit is set.
- R5: On the second `inta` strobe, `vec_out` becomes {base, level}, and `vec_valid` is high for exactly the following cycle. The base is written as bits 7:3 of a write to port 2, and bits 2:0 of that write are dropped.
- R6: If no request is eligible at the first strobe, the vector carries level 7 and the in-service register does not change.
- R7: Writing 0x0C to port 0 arms a poll. The next read of port 0 returns bit 7 set when a request was eligible, with the level in bits 2:0, and accepts that level as in R4. With nothing eligible, the read returns 0x07 and accepts nothing. The poll is disarmed by that read.
- R8: Writing 0x0A to port 0 makes later non-poll reads of port 0 return the request register. Writing 0x0B makes them return the in-service register.
- R9: Port 1 holds the mask, readable and writable. A masked line still latches into the request register but cannot raise `int_out` or win.
- R10: Writing 0x20 to port 0 clears the lowest-indexed set in-service bit, and only that bit.
- R11: After reset, the request, in-service and mask registers and the base are zero. `int_out` and `vec_valid` are low, and port 0 reads the request register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_in | input | 8 | Interrupt request lines, rising-edge sensitive |
| int_out | output | 1 | Interrupt request to the processor |
| inta | input | 1 | Acknowledge strobe, one cycle per pulse |
| vec_out | output | 8 | Vector presented after the second strobe |
| vec_valid | output | 1 | High for one cycle when `vec_out` is fresh |
| bus_addr | input | 2 | Port select: 0 command/status, 1 mask, 2 base |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (read side effects apply at the clock edge) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed port |

## Verification
Two requests raised in the same cycle show whether the scan picks the lower index. A lower-index request raised while a higher index is in service shows whether nesting preempts. A pending request with a higher index than the one in service shows whether it is correctly held off. A line held high across its acceptance separates edge latching from level latching. A masked-only request and a fully empty request register both drive the false-interrupt path, and each must give level 7 with an unchanged in-service register. The poll path is tried with a request pending and with none pending, and a following plain read separates a one-shot poll from one that stays armed.

// File: rtl/irq_ctrl8_pkg.sv
package irq_ctrl8_pkg;
   localparam logic [7:0] CMD_POLL    = 8'h0C;
   localparam logic [7:0] CMD_SEL_IRR = 8'h0A;
   localparam logic [7:0] CMD_SEL_ISR = 8'h0B;
   localparam logic [7:0] CMD_EOI     = 8'h20;

   typedef enum logic [1:0] {
      PORT_CMD  = 2'd0,
      PORT_MASK = 2'd1,
      PORT_BASE = 2'd2,
      PORT_NONE = 2'd3
   } port_e;
endpackage

// File: rtl/irq_prio_scan.sv
module irq_prio_scan #(
   parameter int  W         = 8,
   parameter bit  LOW_WINS  = 1'b1,
   localparam int IW        = $clog2(W)
) (
   input  logic [W-1:0]  vec,
   output logic          found,
   output logic [IW-1:0] idx,
   output logic [W-1:0]  onehot
);
   generate
      if (W < 2) begin : g_bad_width
         $error("irq_prio_scan: W must be at least 2");
      end
      if (LOW_WINS) begin : g_low_first
         always_comb begin
            found = 1'b0;
            idx   = '0;
            for (int i = W - 1; i >= 0; i--) begin
               if (vec[i]) begin
                  found = 1'b1;
                  idx   = IW'(i);
               end
            end
         end
      end else begin : g_high_first
         always_comb begin
            found = 1'b0;
            idx   = '0;
            for (int i = 0; i < W; i++) begin
               if (vec[i]) begin
                  found = 1'b1;
                  idx   = IW'(i);
               end
            end
         end
      end
   endgenerate

   assign onehot = {{(W-1){1'b0}}, found} << idx;
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] req_in,
   input  logic [W-1:0] clr,
   output logic [W-1:0] irr
);
   logic [W-1:0] prev_q;
   logic [W-1:0] rise;

   assign rise = req_in & ~prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= '0;
         irr    <= '0;
      end else begin
         prev_q <= req_in;
         irr    <= (irr & ~clr) | rise;
      end
   end

   // R1: a pending bit only drops when it was being accepted
   a_r1_irr_holds: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(irr) & ~irr) & ~$past(clr)) == '0));
endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq #(
   parameter int LVL_W  = 3,
   parameter int BASE_W = 5,
   localparam int VW    = LVL_W + BASE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inta,
   input  logic              win_found,
   input  logic [LVL_W-1:0]  win_lvl,
   input  logic [BASE_W-1:0] base,
   output logic              first,
   output logic [VW-1:0]     vec_out,
   output logic              vec_valid
);
   logic             phase_q;
   logic [LVL_W-1:0] lvl_q;

   assign first = inta && !phase_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q   <= 1'b0;
         lvl_q     <= '0;
         vec_out   <= '0;
         vec_valid <= 1'b0;
      end else begin
         vec_valid <= 1'b0;
         if (inta) begin
            phase_q <= !phase_q;
            if (!phase_q) begin
               lvl_q <= win_found ? win_lvl : '1;
            end else begin
               vec_out   <= {base, lvl_q};
               vec_valid <= 1'b1;
            end
         end
      end
   end

   // R5: the vector strobe lasts one cycle
   a_r5_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |=> !vec_valid);
   // R6: an empty first strobe yields the all-ones level
   a_r6_spurious_level: assert property (@(posedge clk) disable iff (!rst_n)
      (first && !win_found) |=> (lvl_q == '1));
endmodule

// File: rtl/irq_ctrl8.sv
module irq_ctrl8
   import irq_ctrl8_pkg::*;
#(
   parameter int  LINES  = 8,
   parameter int  VEC_W  = 8,
   localparam int LVL_W  = $clog2(LINES),
   localparam int BASE_W = VEC_W - LVL_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] req_in,
   output logic             int_out,
   input  logic             inta,
   output logic [VEC_W-1:0] vec_out,
   output logic             vec_valid,
   input  logic [1:0]       bus_addr,
   input  logic             bus_wr,
   input  logic             bus_rd,
   input  logic [VEC_W-1:0] bus_wdata,
   output logic [VEC_W-1:0] bus_rdata
);
   generate
      if ((1 << LVL_W) != LINES) begin : g_chk_pow2
         $error("irq_ctrl8: LINES must be a power of two");
      end
      if (LINES > VEC_W || VEC_W < LVL_W + 1 || VEC_W != 8) begin : g_chk_bus
         $error("irq_ctrl8: bus width must be 8 and hold every line");
      end
   endgenerate

   logic [LINES-1:0]  irr, isr_q, mask_q, blk, elig;
   logic [LINES-1:0]  win_oh, isr_oh, isr_set, isr_clr, irr_clr;
   logic [LVL_W-1:0]  win_lvl, isr_lvl;
   logic              win_found, isr_found;
   logic [BASE_W-1:0] base_q;
   logic              poll_armed_q, sel_isr_q;
   logic              cmd_wr, poll_rd, first, take, take_hit, eoi;

   // blocking by any level at or above in urgency
   generate
      for (genvar g = 0; g < LINES; g++) begin : g_blk
         if (g == 0) begin : g_first
            assign blk[g] = isr_q[g];
         end else begin : g_rest
            assign blk[g] = blk[g-1] | isr_q[g];
         end
      end
   endgenerate

   assign elig    = irr & ~mask_q & ~blk;
   assign int_out = |elig;

   irq_prio_scan #(.W(LINES), .LOW_WINS(1'b1)) u_win_scan (
      .vec(elig), .found(win_found), .idx(win_lvl), .onehot(win_oh));

   irq_prio_scan #(.W(LINES), .LOW_WINS(1'b1)) u_isr_scan (
      .vec(isr_q), .found(isr_found), .idx(isr_lvl), .onehot(isr_oh));

   irq_req_latch #(.W(LINES)) u_req (
      .clk(clk), .rst_n(rst_n), .req_in(req_in), .clr(irr_clr), .irr(irr));

   irq_ack_seq #(.LVL_W(LVL_W), .BASE_W(BASE_W)) u_ack (
      .clk(clk), .rst_n(rst_n), .inta(inta), .win_found(win_found),
      .win_lvl(win_lvl), .base(base_q), .first(first),
      .vec_out(vec_out), .vec_valid(vec_valid));

   assign cmd_wr   = bus_wr && (bus_addr == PORT_CMD);
   assign poll_rd  = bus_rd && (bus_addr == PORT_CMD) && poll_armed_q;
   assign take     = first || poll_rd;
   assign take_hit = take && win_found;
   assign eoi      = cmd_wr && (bus_wdata == CMD_EOI);
   assign isr_set  = take_hit ? win_oh : '0;
   assign irr_clr  = isr_set;
   assign isr_clr  = (eoi && isr_found) ? isr_oh : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         isr_q        <= '0;
         mask_q       <= '0;
         base_q       <= '0;
         poll_armed_q <= 1'b0;
         sel_isr_q    <= 1'b0;
      end else begin
         isr_q <= (isr_q & ~isr_clr) | isr_set;
         if (poll_rd) poll_armed_q <= 1'b0;
         if (cmd_wr) begin
            case (bus_wdata)
               CMD_POLL:    poll_armed_q <= 1'b1;
               CMD_SEL_IRR: sel_isr_q    <= 1'b0;
               CMD_SEL_ISR: sel_isr_q    <= 1'b1;
               default:     ;
            endcase
         end
         if (bus_wr && bus_addr == PORT_MASK) mask_q <= bus_wdata[LINES-1:0];
         if (bus_wr && bus_addr == PORT_BASE) base_q <= bus_wdata[VEC_W-1:LVL_W];
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         PORT_CMD: begin
            if (poll_armed_q) begin
               bus_rdata[VEC_W-1]   = win_found;
               bus_rdata[LVL_W-1:0] = win_found ? win_lvl : '1;
            end else begin
               bus_rdata = VEC_W'(sel_isr_q ? isr_q : irr);
            end
         end
         PORT_MASK: bus_rdata = VEC_W'(mask_q);
         PORT_BASE: bus_rdata = {base_q, {LVL_W{1'b0}}};
         default:   bus_rdata = '0;
      endcase
   end

   // R2: the output never rises without an unmasked pending bit
   a_r2_int_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      int_out |-> ((irr & ~mask_q) != '0));
   // R3: the accepted level has no eligible bit below it
   a_r3_lowest_taken: assert property (@(posedge clk) disable iff (!rst_n)
      take_hit |-> ((elig & (win_oh - 1'b1)) == '0));
   // R4: one acceptance adds at most one in-service bit
   a_r4_isr_grows_by_one: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ($countones(isr_q) <= $countones($past(isr_q)) + 1));
   // R6: an empty acceptance leaves the in-service register alone
   a_r6_spurious_keeps_isr: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !win_found && !eoi) |=> (isr_q == $past(isr_q)));
   // R10: end-of-interrupt retires exactly one level
   a_r10_eoi_drops_one: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && isr_q != '0 && !take_hit) |=>
         ($countones(isr_q) + 1 == $countones($past(isr_q))));
endmodule

// File: tb/irq_ctrl8_test.sv
`timescale 1ns/1ps
module irq_ctrl8_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] req_in = '0;
   logic       int_out;
   logic       inta = 1'b0;
   logic [7:0] vec_out;
   logic       vec_valid;
   logic [1:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #2.5 clk = ~clk;

   irq_ctrl8 uut (
      .clk(clk), .rst_n(rst_n), .req_in(req_in), .int_out(int_out),
      .inta(inta), .vec_out(vec_out), .vec_valid(vec_valid),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #0.5 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic pulse;
      @(negedge clk);
      inta = 1'b1;
      @(negedge clk);
      inta = 1'b0;
   endtask

   task automatic set_req(input logic [7:0] v);
      @(negedge clk);
      req_in = v;
      @(negedge clk);
   endtask

   task automatic read_irr(output logic [7:0] d);
      wr(2'd0, 8'h0A); rd(2'd0, d);
   endtask

   task automatic read_isr(output logic [7:0] d);
      wr(2'd0, 8'h0B); rd(2'd0, d);
   endtask

   task automatic full_ack(input string tag, input logic [7:0] exp_vec);
      pulse; pulse;
      chk({tag, " vec_valid"}, {7'd0, vec_valid}, 8'h01);
      chk({tag, " vec_out"}, vec_out, exp_vec);
   endtask

   task automatic t_reset;
      logic [7:0] d;
      chk("R11 int_out", {7'd0, int_out}, 8'h00);
      chk("R11 vec_valid", {7'd0, vec_valid}, 8'h00);
      rd(2'd0, d); chk("R11 port0 reads irr", d, 8'h00);
      rd(2'd1, d); chk("R11 mask", d, 8'h00);
      rd(2'd2, d); chk("R11 base", d, 8'h00);
   endtask

   task automatic t_edge_and_ack;
      logic [7:0] d;
      wr(2'd2, 8'hAD);
      rd(2'd2, d); chk("R5 base drops low bits", d, 8'hA8);
      set_req(8'h08);
      read_irr(d); chk("R1 edge latches", d, 8'h08);
      chk("R2 int_out raised", {7'd0, int_out}, 8'h01);
      pulse;
      read_isr(d); chk("R4 isr set", d, 8'h08);
      read_irr(d); chk("R1 held line not relatched", d, 8'h00);
      chk("R2 int_out dropped", {7'd0, int_out}, 8'h00);
      pulse;
      chk("R5 vec_valid", {7'd0, vec_valid}, 8'h01);
      chk("R5 vector", vec_out, 8'hAB);
      @(negedge clk);
      chk("R5 vec_valid one cycle", {7'd0, vec_valid}, 8'h00);
      wr(2'd0, 8'h20);
      read_isr(d); chk("R10 eoi clears", d, 8'h00);
      set_req(8'h00);
   endtask

   task automatic t_priority_nest;
      logic [7:0] d;
      set_req(8'h24);
      chk("R2 two pending", {7'd0, int_out}, 8'h01);
      full_ack("R3 lower wins", 8'hAA);
      read_isr(d); chk("R4 isr bit2", d, 8'h04);
      read_irr(d); chk("R4 irr keeps bit5", d, 8'h20);
      chk("R2 lower urgency held off", {7'd0, int_out}, 8'h00);
      set_req(8'h26);
      chk("R2 more urgent nests", {7'd0, int_out}, 8'h01);
      full_ack("R3 nested level1", 8'hA9);
      read_isr(d); chk("R4 isr nested", d, 8'h06);
      wr(2'd0, 8'h20);
      read_isr(d); chk("R10 lowest cleared only", d, 8'h04);
      chk("R2 still held off", {7'd0, int_out}, 8'h00);
      wr(2'd0, 8'h20);
      read_isr(d); chk("R10 second eoi", d, 8'h00);
      chk("R2 bit5 now offered", {7'd0, int_out}, 8'h01);
      full_ack("R3 level5", 8'hAD);
      wr(2'd0, 8'h20);
      set_req(8'h00);
   endtask

   task automatic t_mask;
      logic [7:0] d;
      wr(2'd1, 8'h01);
      rd(2'd1, d); chk("R9 mask readback", d, 8'h01);
      set_req(8'h01);
      read_irr(d); chk("R9 masked still latched", d, 8'h01);
      chk("R9 masked no int", {7'd0, int_out}, 8'h00);
      wr(2'd1, 8'h00);
      chk("R9 unmasked int", {7'd0, int_out}, 8'h01);
      full_ack("R9 level0", 8'hA8);
      wr(2'd0, 8'h20);
      set_req(8'h00);
   endtask

   task automatic t_spurious;
      logic [7:0] d;
      chk("R6 idle int", {7'd0, int_out}, 8'h00);
      full_ack("R6 empty gives 7", 8'hAF);
      read_isr(d); chk("R6 isr untouched", d, 8'h00);
      wr(2'd1, 8'h10);
      set_req(8'h10);
      full_ack("R6 masked gives 7", 8'hAF);
      read_isr(d); chk("R6 isr untouched masked", d, 8'h00);
      read_irr(d); chk("R6 irr kept", d, 8'h10);
      wr(2'd1, 8'h00);
   endtask

   task automatic t_poll;
      logic [7:0] d;
      wr(2'd0, 8'h0C);
      rd(2'd0, d); chk("R7 poll word", d, 8'h84);
      read_irr(d); chk("R7 poll cleared irr", d, 8'h00);
      read_isr(d); chk("R7 poll set isr", d, 8'h10);
      wr(2'd0, 8'h20);
      wr(2'd0, 8'h0C);
      rd(2'd0, d); chk("R7 empty poll", d, 8'h07);
      rd(2'd0, d); chk("R7 poll one shot", d, 8'h00);
      wr(2'd0, 8'h0A);
      rd(2'd0, d); chk("R8 irr select", d, 8'h00);
      set_req(8'h00);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_edge_and_ack;
      t_priority_nest;
      t_mask;
      t_spurious;
      t_poll;
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end
endmodule